// File: doc/BRIEF.md
# Bidirectional Row-Scan Shift Register

This block selects display rows one at a time by moving a token, or any bit pattern, along a long chain of stages. The chain moves one place for every falling edge of an external latch pulse. The pulse is brought into the system clock domain and edge-detected before it is used. The chain can be used whole (default 240 stages) or as two independent halves. It can run towards the last stage or towards the first.

The two end pins change roles with the direction. The pin at the head of the active path takes data in. The pin at the tail drives out the bit held in the last stage of the path, so that several devices can be cascaded. In split mode a separate middle input feeds the second half. The end output then reports the tail of the first half.

A display-enable input, when low, blanks every row and clears the chain. While display is enabled, a frame-inversion input and each stage's bit together choose one of four drive-level codes for that row.

Top module: `row_scan_shifter`

## Requirements
- R1: The chain moves by exactly one position for each falling edge of `lp_i`. The result is visible on the outputs no later than the fourth rising edge of `clk` after the fall. With no falling edge, the chain holds its contents.
- R2: Whole chain, `dir_fwd_i`=1: stage 1 loads `end1_i` and every other stage k loads stage k-1.
- R3: Whole chain, `dir_fwd_i`=0: the last stage loads `end2_i` and every other stage k loads stage k+1.
- R4: Split mode (`dual_i`=1): each half shifts on its own. Going forward, stage STAGES/2+1 loads `mid_i`. Going in reverse, stage STAGES/2 loads `mid_i`.
- R5: With `dir_fwd_i`=1, `end2_oe_o`=1 and `end1_oe_o`=0. With `dir_fwd_i`=0, the enables are reversed. The output of a pin acting as an input reads 0.
- R6: The enabled end output carries the current last stage of the active path. In whole mode this is stage STAGES going forward and stage 1 in reverse. In split mode it is the first half's tail: stage STAGES/2 going forward and stage STAGES/2+1 in reverse.
- R7: While `disp_en_i`=0, the chain is cleared on every clock and a latch pulse shifts nothing in. The clear wins over a shift.
- R8: While `disp_en_i`=0, every row code is 3.
- R9: With `disp_en_i`=1, row k's code is held in `row_lvl_o[2k-1:2k-2]`. Level codes are 0=V0, 1=V12, 2=V43, 3=V5. The code is set by (frame, bit) as follows: (0,0)→2, (0,1)→0, (1,0)→1, (1,1)→3.
- R10: After reset, all stages hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_i | input | 1 | Latch pulse, asynchronous; the falling edge shifts |
| dir_fwd_i | input | 1 | 1: shift from stage 1 toward the last stage |
| dual_i | input | 1 | 1: two half-length chains |
| end1_i | input | 1 | Data in at the stage-1 end pin |
| end2_i | input | 1 | Data in at the last-stage end pin |
| mid_i | input | 1 | Second-half data in for split mode |
| disp_en_i | input | 1 | 0: blank all rows and clear the chain |
| frame_i | input | 1 | Frame inversion |
| end1_o | output | 1 | Stage-1 end pin output value |
| end1_oe_o | output | 1 | Stage-1 end pin drives |
| end2_o | output | 1 | Last-stage end pin output value |
| end2_oe_o | output | 1 | Last-stage end pin drives |
| row_lvl_o | output | 2*STAGES | Two-bit level code per row |

## Verification
The assertions assume that direction, mode, the data inputs and display-enable are steady around each rising clock edge. They also assume that the synchronised latch pulse never falls in two clocks running. The bench keeps within these assumptions. It changes every input on the falling clock edge only. It holds the latch pulse at each level for four clocks, so each fall yields one clean detected edge. Direction and mode are changed only between sweeps, and each sweep begins with a clear through display-enable.

// File: rtl/rss_pkg.sv
package rss_pkg;

    typedef enum logic [1:0] {
        LVL_V0  = 2'd0,
        LVL_V12 = 2'd1,
        LVL_V43 = 2'd2,
        LVL_V5  = 2'd3
    } lvl_e;

    // Drive level for one row from display enable, frame phase and stage bit.
    function automatic lvl_e row_level(input logic on, input logic frame, input logic sel);
        lvl_e r;
        if (!on)
            r = LVL_V5;
        else begin
            unique case ({frame, sel})
                2'b00:   r = LVL_V43;
                2'b01:   r = LVL_V0;
                2'b10:   r = LVL_V12;
                default: r = LVL_V5;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rss_lp_sync.sv
module rss_lp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_i,
    output logic fall_o
);
    typedef struct packed {
        logic meta;
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = lp_i;
        st_d.s1   = st_q.meta;
        st_d.s2   = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fall_o = st_q.s2 & ~st_q.s1;

    // R1: one detected edge per fall of the pulse
    assert_single_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/rss_chain.sv
module rss_chain #(
    parameter int STAGES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              clear_i,
    input  logic              dir_fwd_i,
    input  logic              dual_i,
    input  logic              end1_i,
    input  logic              end2_i,
    input  logic              mid_i,
    output logic [STAGES-1:0] chain_o,
    output logic              end1_o,
    output logic              end1_oe_o,
    output logic              end2_o,
    output logic              end2_oe_o
);
    localparam int HALF = STAGES / 2;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } chain_t;

    chain_t st_d, st_q;
    logic [STAGES-1:0] fwd_next, rev_next;

    always_comb begin
        fwd_next = {st_q.chain[STAGES-2:0], end1_i};
        rev_next = {end2_i, st_q.chain[STAGES-1:1]};
        if (dual_i) begin
            fwd_next[HALF]   = mid_i;
            rev_next[HALF-1] = mid_i;
        end
        st_d = st_q;
        if (clear_i)
            st_d.chain = '0;
        else if (shift_i)
            st_d.chain = dir_fwd_i ? fwd_next : rev_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign chain_o   = st_q.chain;
    assign end1_oe_o = ~dir_fwd_i;
    assign end2_oe_o = dir_fwd_i;
    assign end1_o    = dir_fwd_i ? 1'b0 : (dual_i ? st_q.chain[HALF] : st_q.chain[0]);
    assign end2_o    = dir_fwd_i ? (dual_i ? st_q.chain[HALF-1] : st_q.chain[STAGES-1]) : 1'b0;

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (chain_o == '0));

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clear_i) |=> (chain_o == $past(chain_o)));

    assert_fwd_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i && dir_fwd_i) |=> (chain_o[0] == $past(end1_i)));

    assert_rev_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i && !dir_fwd_i) |=> (chain_o[STAGES-1] == $past(end2_i)));

    assert_mid_inject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i && dual_i && dir_fwd_i) |=> (chain_o[HALF] == $past(mid_i)));

endmodule

// File: rtl/rss_levels.sv
module rss_levels #(
    parameter int STAGES = 240
) (
    input  logic                  disp_en_i,
    input  logic                  frame_i,
    input  logic [STAGES-1:0]     chain_i,
    output logic [2*STAGES-1:0]   lvl_o
);
    import rss_pkg::*;

    for (genvar i = 0; i < STAGES; i++) begin : g_row
        assign lvl_o[2*i +: 2] = row_level(disp_en_i, frame_i, chain_i[i]);
    end

endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
    parameter int STAGES = 240
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lp_i,
    input  logic                dir_fwd_i,
    input  logic                dual_i,
    input  logic                end1_i,
    input  logic                end2_i,
    input  logic                mid_i,
    input  logic                disp_en_i,
    input  logic                frame_i,
    output logic                end1_o,
    output logic                end1_oe_o,
    output logic                end2_o,
    output logic                end2_oe_o,
    output logic [2*STAGES-1:0] row_lvl_o
);
    logic              lp_fall;
    logic [STAGES-1:0] chain;

    rss_lp_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lp_i   (lp_i),
        .fall_o (lp_fall)
    );

    rss_chain #(.STAGES(STAGES)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (lp_fall),
        .clear_i   (~disp_en_i),
        .dir_fwd_i (dir_fwd_i),
        .dual_i    (dual_i),
        .end1_i    (end1_i),
        .end2_i    (end2_i),
        .mid_i     (mid_i),
        .chain_o   (chain),
        .end1_o    (end1_o),
        .end1_oe_o (end1_oe_o),
        .end2_o    (end2_o),
        .end2_oe_o (end2_oe_o)
    );

    rss_levels #(.STAGES(STAGES)) u_levels (
        .disp_en_i (disp_en_i),
        .frame_i   (frame_i),
        .chain_i   (chain),
        .lvl_o     (row_lvl_o)
    );

    assert_blank_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_i |-> (row_lvl_o == '1));

    assert_pin_roles_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end1_oe_o != end2_oe_o) && (end2_oe_o == dir_fwd_i));

endmodule

// File: tb/row_scan_shifter_test.sv
module row_scan_shifter_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int H = N / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lp = 1'b0, dir_fwd = 1'b1, dual = 1'b0;
    logic end1_in = 1'b0, end2_in = 1'b0, mid_in = 1'b0;
    logic disp_en = 1'b1, frame = 1'b0;
    logic end1_out, end1_oe, end2_out, end2_oe;
    logic [2*N-1:0] row_lvl;

    logic [N-1:0] m;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_scan_shifter #(.STAGES(N)) uut (
        .clk(clk), .rst_n(rst_n), .lp_i(lp), .dir_fwd_i(dir_fwd), .dual_i(dual),
        .end1_i(end1_in), .end2_i(end2_in), .mid_i(mid_in), .disp_en_i(disp_en),
        .frame_i(frame), .end1_o(end1_out), .end1_oe_o(end1_oe), .end2_o(end2_out),
        .end2_oe_o(end2_oe), .row_lvl_o(row_lvl)
    );

    function automatic logic [2*N-1:0] expect_lvl(input logic [N-1:0] bits, input logic on, input logic fr);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) begin
            int c;
            if (!on) c = 3;
            else c = fr ? (bits[i] ? 3 : 1) : (bits[i] ? 0 : 2);
            v[2*i +: 2] = c[1:0];
        end
        return v;
    endfunction

    task automatic check_rows(input string tag);
        logic [2*N-1:0] e;
        e = expect_lvl(m, disp_en, frame);
        checks++;
        if (row_lvl !== e) begin
            fails++;
            $display("FAIL %s rows: actual %h expected %h", tag, row_lvl, e);
        end
    endtask

    task automatic check_pins(input string tag);
        logic [3:0] a, e;
        logic t;
        t = dir_fwd ? (dual ? m[H-1] : m[N-1]) : (dual ? m[H] : m[0]);
        e = dir_fwd ? {1'b0, 1'b0, t, 1'b1} : {t, 1'b1, 1'b0, 1'b0};
        a = {end1_out, end1_oe, end2_out, end2_oe};
        checks++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s pins {e1,oe1,e2,oe2}: actual %b expected %b", tag, a, e);
        end
    endtask

    // Model step following R2/R3/R4
    task automatic model_shift();
        logic [N-1:0] nx;
        if (dir_fwd) begin
            nx = {m[N-2:0], end1_in};
            if (dual) nx[H] = mid_in;
        end else begin
            nx = {end2_in, m[N-1:1]};
            if (dual) nx[H-1] = mid_in;
        end
        m = nx;
    endtask

    task automatic pulse();
        @(negedge clk) lp = 1'b1;
        repeat (4) @(negedge clk);
        lp = 1'b0;
        repeat (4) @(negedge clk);
        if (disp_en) model_shift();
    endtask

    task automatic clear_chain();
        @(negedge clk) disp_en = 1'b0;
        repeat (2) @(negedge clk);
        disp_en = 1'b1;
        m = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_rows("R10 reset");
        check_pins("R5 reset");

        for (int mode = 0; mode < 4; mode++) begin
            dir_fwd = ~mode[0];
            dual    = mode[1];
            clear_chain();
            for (int step = 0; step < 2 * N + 2; step++) begin
                end1_in = ((step * 5 + mode) % 3) == 0;
                end2_in = ((step * 3 + mode) % 4) < 2;
                mid_in  = ((step + mode) % 5) == 1;
                frame   = step[1];
                pulse();
                check_rows(dual ? "R4 R9 split shift" : (dir_fwd ? "R2 R9 fwd shift" : "R3 R9 rev shift"));
                check_pins("R5 R6 end pins");
            end
            // R1: inputs move but no pulse -> nothing changes
            @(negedge clk);
            end1_in = ~end1_in; end2_in = ~end2_in; mid_in = ~mid_in;
            repeat (8) @(negedge clk);
            check_rows("R1 idle hold");
            check_pins("R1 idle pins");
        end

        // R7/R8: fill with ones, blank, pulse while blanked, re-enable
        dir_fwd = 1'b1; dual = 1'b0;
        end1_in = 1'b1; end2_in = 1'b1; mid_in = 1'b1; frame = 1'b1;
        for (int k = 0; k < N; k++) pulse();
        check_rows("R2 filled");
        @(negedge clk) disp_en = 1'b0;
        @(negedge clk);
        m = '0;
        check_rows("R8 blank level");
        pulse();
        check_rows("R8 blank during pulse");
        @(negedge clk) disp_en = 1'b1;
        @(negedge clk);
        check_rows("R7 cleared after blank");
        check_pins("R7 end pin cleared");
        frame = 1'b0;
        @(negedge clk);
        check_rows("R9 frame low zeros");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule